// File: doc/BRIEF.md
# Programmable Violation Word Generator

This block builds a repeating test word and drives it onto a pair of line outputs. All timing comes from a slow sample clock, nominally 600 Hz, that is applied as a level on `sclk_i`. Every rising edge of that clock, seen in the fast system clock domain, advances the sequence by one sample period. Each word opens with a sync interval, which by default is four sample periods (about 6.7 ms). Seven bit slots follow in a fixed order. Three of those slots can be stretched at run time: each has its own width-select bit, and the bit picks one sample period or two. The four remaining slots always last one period.

The slot levels come from a fixed pattern. Each level is XORed with a polarity bit. At the end of every word the polarity bit takes the level of the last slot sent, so the output sign follows the most recent transition. A mode input selects the coding. In level coding, one line carries the whole slot. In return-to-zero coding, two lines carry pulses, one line for marks and the other for spaces. While disabled, both lines rest high. A one-cycle strobe marks each word boundary.

Top module: `vw_gen`

## Requirements
- R1: During reset, and from the second clock edge after `en_i` is sampled low, both line outputs are high and `strobe_o` stays low. Disabling also clears the polarity bit to 0.
- R2: When enabled, a word starts on the first sample-clock rising edge. The word runs through the sync interval (SYNC_TICKS periods) and then slots 0 to 6 in ascending order. Slot k carries bit k of WORD_PAT (default 7'b1001101) XOR the polarity bit. The next word follows at once.
- R3: Slot 1 is governed by `wsel_i[0]`, slot 3 by `wsel_i[1]` and slot 5 by `wsel_i[2]`. A value of 0 gives one sample period and 1 gives LONG_TICKS periods (default 2). All other slots last one period.
- R4: The width-select bits are captured only on the sample edge that starts a word. Changes during a word have no effect on that word.
- R5: `strobe_o` is high for exactly one system clock at the start of each word, including the first word after enabling.
- R6: Level mode (`mode_i`=0): `line_a_o` holds the slot level for the whole slot and `line_b_o` stays high. During the sync interval `line_a_o` holds the current polarity bit, which is the last level sent.
- R7: Return-to-zero mode (`mode_i`=1): during the high phase of a slot's first sample period, a mark (level 1) drives `line_a_o` high and a space (level 0) drives `line_b_o` high, with the other line low. At all other times while a word is running, including the sync interval, both lines are low.
- R8: At the end of slot 6 the polarity bit becomes the level just sent. The next word's levels and sync level are inverted when that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Start/enable; low forces the idle state |
| sclk_i | input | 1 | Sample clock level, synchronous to clk_i |
| mode_i | input | 1 | 0 = level coding, 1 = return-to-zero coding |
| wsel_i | input | NUM_PROG | Width selects for slots 1, 3, 5 (bit 0 = slot 1) |
| line_a_o | output | 1 | Mark line (level line in level mode) |
| line_b_o | output | 1 | Space line (held high in level mode) |
| strobe_o | output | 1 | One-cycle word-start strobe |

## Verification
Suppose `sclk_i` is first seen high at edge E0. The sequencer steps at E0. The line register and the strobe update at E1, so every line level and strobe is due two rising edges after the sample edge is seen. The falling half of the sample clock reaches the return-to-zero lines with the same two-edge delay. The bench changes every input at a falling edge of the system clock. It checks the lines at the second falling edge after each sample-clock transition and counts strobes across the whole sample period. Changes to the enable and the mode are made only at sample-period starts, so they share the same two-edge timing.

// File: rtl/vw_pkg.sv
package vw_pkg;
  localparam int NUM_SLOTS = 7;
  localparam int IDX_W     = 3;
  localparam int LAST_SLOT = NUM_SLOTS - 1;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_SLOT = 2'd2
  } vw_phase_e;
endpackage

// File: rtl/vw_tick.sv
module vw_tick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic tick_o,
  output logic lvl_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign tick_o = sclk_i & ~sclk_q;
  assign lvl_o  = sclk_q;
endmodule

// File: rtl/vw_seq.sv
module vw_seq
  import vw_pkg::*;
#(
  parameter int                   SYNC_TICKS = 4,
  parameter int                   LONG_TICKS = 2,
  parameter int                   NUM_PROG   = 3,
  parameter logic [NUM_SLOTS-1:0] WORD_PAT   = 7'b1001101,
  parameter int                   CNT_W      = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic [NUM_PROG-1:0] wsel_i,
  output vw_phase_e           phase_o,
  output logic                first_o,
  output logic                level_o,
  output logic                pol_o,
  output logic                strobe_o,
  output logic [NUM_PROG-1:0] wsel_o
);
  localparam int                 TAB_N  = 2 ** IDX_W;
  localparam logic [TAB_N-1:0]   PAT_X  = TAB_N'(WORD_PAT);
  localparam logic [CNT_W-1:0]   SYNC_M = CNT_W'(SYNC_TICKS - 1);
  localparam logic [CNT_W-1:0]   LONG_M = CNT_W'(LONG_TICKS - 1);

  vw_phase_e           phase_q;
  logic [IDX_W-1:0]    idx_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                first_q;
  logic                pol_q;
  logic                strobe_q;
  logic [NUM_PROG-1:0] wsel_q;
  logic [CNT_W-1:0]    slot_len [TAB_N];
  logic [IDX_W-1:0]    idx_nxt;

  // period count minus one per slot; odd slots below 2*NUM_PROG are programmable
  for (genvar k = 0; k < TAB_N; k++) begin : g_len
    if ((k % 2 == 1) && (k / 2 < NUM_PROG) && (k < NUM_SLOTS)) begin : g_prog
      assign slot_len[k] = wsel_q[k/2] ? LONG_M : '0;
    end else begin : g_fix
      assign slot_len[k] = '0;
    end
  end

  assign idx_nxt = idx_q + 1'b1;
  assign level_o = PAT_X[idx_q] ^ pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      first_q  <= 1'b0;
      pol_q    <= 1'b0;
      strobe_q <= 1'b0;
      wsel_q   <= '0;
    end else begin
      strobe_q <= 1'b0;
      if (!en_i) begin
        phase_q <= PH_IDLE;
        idx_q   <= '0;
        cnt_q   <= '0;
        first_q <= 1'b0;
        pol_q   <= 1'b0;
      end else if (tick_i) begin
        first_q <= 1'b0;
        unique case (phase_q)
          PH_IDLE: begin
            phase_q  <= PH_SYNC;
            cnt_q    <= SYNC_M;
            wsel_q   <= wsel_i;
            strobe_q <= 1'b1;
          end
          PH_SYNC: begin
            if (cnt_q == '0) begin
              phase_q <= PH_SLOT;
              idx_q   <= '0;
              cnt_q   <= slot_len[0];
              first_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          PH_SLOT: begin
            if (cnt_q != '0) begin
              cnt_q <= cnt_q - 1'b1;
            end else if (idx_q == IDX_W'(LAST_SLOT)) begin
              pol_q    <= level_o;
              phase_q  <= PH_SYNC;
              cnt_q    <= SYNC_M;
              wsel_q   <= wsel_i;
              strobe_q <= 1'b1;
            end else begin
              idx_q   <= idx_nxt;
              cnt_q   <= slot_len[idx_nxt];
              first_q <= 1'b1;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase_o  = phase_q;
  assign first_o  = first_q;
  assign pol_o    = pol_q;
  assign strobe_o = strobe_q;
  assign wsel_o   = wsel_q;
endmodule

// File: rtl/vw_line.sv
module vw_line
  import vw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      mode_i,
  input  vw_phase_e phase_i,
  input  logic      first_i,
  input  logic      level_i,
  input  logic      pol_i,
  input  logic      strobe_i,
  input  logic      sclk_lvl_i,
  output logic      line_a_o,
  output logic      line_b_o,
  output logic      strobe_o
);
  logic a_d, b_d, pulse;

  assign pulse = (phase_i == PH_SLOT) && first_i && sclk_lvl_i;

  always_comb begin
    if (phase_i == PH_IDLE) begin
      a_d = 1'b1;
      b_d = 1'b1;
    end else if (!mode_i) begin
      a_d = (phase_i == PH_SYNC) ? pol_i : level_i;
      b_d = 1'b1;
    end else begin
      a_d = pulse & level_i;
      b_d = pulse & ~level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_a_o <= 1'b1;
      line_b_o <= 1'b1;
      strobe_o <= 1'b0;
    end else begin
      line_a_o <= a_d;
      line_b_o <= b_d;
      strobe_o <= strobe_i;
    end
  end
endmodule

// File: rtl/vw_gen.sv
module vw_gen
  import vw_pkg::*;
#(
  parameter int                   SYNC_TICKS = 4,
  parameter int                   LONG_TICKS = 2,
  parameter int                   NUM_PROG   = 3,
  parameter logic [NUM_SLOTS-1:0] WORD_PAT   = 7'b1001101
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                sclk_i,
  input  logic                mode_i,
  input  logic [NUM_PROG-1:0] wsel_i,
  output logic                line_a_o,
  output logic                line_b_o,
  output logic                strobe_o
);
  localparam int MAX_T = (SYNC_TICKS > LONG_TICKS) ? SYNC_TICKS : LONG_TICKS;
  localparam int CNT_W = $clog2(MAX_T) + 1;

  logic                tick, sclk_lvl;
  vw_phase_e           seq_phase;
  logic                seq_first, seq_level, seq_pol, seq_strobe;
  logic [NUM_PROG-1:0] wsel_lat;

  vw_tick u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .tick_o (tick),
    .lvl_o  (sclk_lvl)
  );

  vw_seq #(
    .SYNC_TICKS (SYNC_TICKS),
    .LONG_TICKS (LONG_TICKS),
    .NUM_PROG   (NUM_PROG),
    .WORD_PAT   (WORD_PAT),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick),
    .wsel_i   (wsel_i),
    .phase_o  (seq_phase),
    .first_o  (seq_first),
    .level_o  (seq_level),
    .pol_o    (seq_pol),
    .strobe_o (seq_strobe),
    .wsel_o   (wsel_lat)
  );

  vw_line u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .phase_i    (seq_phase),
    .first_i    (seq_first),
    .level_i    (seq_level),
    .pol_i      (seq_pol),
    .strobe_i   (seq_strobe),
    .sclk_lvl_i (sclk_lvl),
    .line_a_o   (line_a_o),
    .line_b_o   (line_b_o),
    .strobe_o   (strobe_o)
  );
endmodule

// File: rtl/vw_gen_chk.sv
module vw_gen_chk
  import vw_pkg::*;
#(
  parameter int NUM_PROG = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                mode_i,
  input logic                line_a_o,
  input logic                line_b_o,
  input logic                strobe_o,
  input vw_phase_e           seq_phase,
  input logic                seq_strobe,
  input logic                seq_pol,
  input logic [NUM_PROG-1:0] wsel_lat
);
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i, 2) |-> (line_a_o && line_b_o && !strobe_o));

  assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wsel_lat) |-> seq_strobe);

  assert_strobe_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  assert_level_b_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mode_i) |-> line_b_o);

  assert_rz_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) && ($past(seq_phase) != PH_IDLE)) |-> !(line_a_o && line_b_o));

  assert_pol_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !seq_pol);
endmodule

bind vw_gen vw_gen_chk #(.NUM_PROG(NUM_PROG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .mode_i     (mode_i),
  .line_a_o   (line_a_o),
  .line_b_o   (line_b_o),
  .strobe_o   (strobe_o),
  .seq_phase  (seq_phase),
  .seq_strobe (seq_strobe),
  .seq_pol    (seq_pol),
  .wsel_lat   (wsel_lat)
);

// File: tb/vw_gen_test.sv
module vw_gen_test;
  localparam int       SYNC = 4;
  localparam int       LONG = 2;
  localparam bit [6:0] PAT  = 7'b1001101;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       sclk_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [2:0] wsel_i = 3'b000;
  logic       line_a_o, line_b_o, strobe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  int       m_ph = 0;  // 0 idle, 1 sync, 2 slot
  int       m_idx = 0;
  int       m_cnt = 0;
  bit [2:0] m_w = 3'b000;
  bit       m_pol = 1'b0;
  bit       m_first = 1'b0;
  bit       m_strobe = 1'b0;

  always #5 clk = ~clk;

  vw_gen uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .sclk_i   (sclk_i),
    .mode_i   (mode_i),
    .wsel_i   (wsel_i),
    .line_a_o (line_a_o),
    .line_b_o (line_b_o),
    .strobe_o (strobe_o)
  );

  function automatic int slen(int k, bit [2:0] w);
    if ((k == 1 && w[0]) || (k == 3 && w[1]) || (k == 5 && w[2])) return LONG;
    return 1;
  endfunction

  task automatic begin_word(bit [2:0] ws);
    m_ph = 1; m_cnt = SYNC - 1; m_w = ws; m_strobe = 1'b1;
  endtask

  task automatic m_step(bit en, bit [2:0] ws);
    m_strobe = 1'b0;
    if (!en) begin
      m_ph = 0; m_pol = 1'b0; m_first = 1'b0; m_idx = 0; m_cnt = 0;
      return;
    end
    m_first = 1'b0;
    case (m_ph)
      0: begin_word(ws);
      1: if (m_cnt == 0) begin
           m_ph = 2; m_idx = 0; m_cnt = slen(0, m_w) - 1; m_first = 1'b1;
         end else m_cnt--;
      default: if (m_cnt != 0) m_cnt--;
         else if (m_idx == 6) begin
           m_pol = PAT[6] ^ m_pol;
           begin_word(ws);
         end else begin
           m_idx++; m_cnt = slen(m_idx, m_w) - 1; m_first = 1'b1;
         end
    endcase
  endtask

  function automatic bit [1:0] exp_lines(bit md, bit hi);
    bit lvl, pulse;
    if (m_ph == 0) return 2'b11;
    lvl = PAT[m_idx] ^ m_pol;
    if (!md) return {(m_ph == 1) ? m_pol : lvl, 1'b1};
    pulse = (m_ph == 2) && m_first && hi;
    return {pulse & lvl, pulse & ~lvl};
  endfunction

  function automatic string tag_for(bit md, bit [2:0] ws);
    if (m_ph == 0) return "R1";
    if (md) return "R7";
    if (m_ph == 1) return "R6";
    if (m_idx[0] && !m_first) return "R3";
    if (m_w != ws) return "R4";
    if (m_pol) return "R8";
    return "R2";
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic run_period(bit en, bit md, bit [2:0] ws);
    int stb = 0;
    en_i = en; mode_i = md; wsel_i = ws; sclk_i = 1'b1;
    m_step(en, ws);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (strobe_o) stb++;
      if (i == 1) chk(tag_for(md, ws), "lines high phase", {line_a_o, line_b_o}, exp_lines(md, 1'b1));
      if (i == 4) sclk_i = 1'b0;
      if (i == 6) chk(tag_for(md, ws), "lines low phase", {line_a_o, line_b_o}, exp_lines(md, 1'b0));
    end
    chk(m_strobe ? "R5" : "R1", "strobe count", stb, m_strobe ? 1 : 0);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    chk("R1", "reset lines", {line_a_o, line_b_o}, 2'b11);
    chk("R1", "reset strobe", strobe_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // disabled: sample clock running, no word
    for (int p = 0; p < 3; p++) run_period(1'b0, 1'b0, 3'b111);
    // level mode, all short, then all long (R2, R3, R8)
    for (int p = 0; p < 22; p++) run_period(1'b1, 1'b0, 3'b000);
    for (int p = 0; p < 28; p++) run_period(1'b1, 1'b0, 3'b111);
    // width bits flipped every period inside a word (R4)
    for (int p = 0; p < 24; p++) run_period(1'b1, 1'b0, p[0] ? 3'b101 : 3'b010);
    // return-to-zero mode (R7)
    for (int p = 0; p < 26; p++) run_period(1'b1, 1'b1, 3'b011);
    // disable mid-word, then restart (R1, R5, R8)
    run_period(1'b0, 1'b1, 3'b000);
    run_period(1'b0, 1'b0, 3'b000);
    for (int p = 0; p < 12; p++) run_period(1'b1, 1'b0, 3'b100);

    // random mix
    begin
      bit md = 1'b0;
      for (int p = 0; p < 2500; p++) begin
        if ($urandom_range(0, 39) == 0) md = ~md;
        run_period($urandom_range(0, 49) != 0, md, 3'($urandom_range(0, 7)));
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule